// File: doc/BRIEF.md
# Chunked Hamming Parity Engine for NAND Data

This block sits on the byte path between a flash controller's data mover and a NAND device. It folds every accepted byte into single-error-correcting Hamming parity, one code per chunk of 256 bytes. When a chunk completes, it publishes a 32-bit parity word. It also publishes the 24-bit code that goes into the spare area, three bytes for every 256 data bytes. Software or a sequencer asserts the clear strobe before each page transfer. It then streams data with the enable high and collects one code per chunk.

A separate syndrome unit takes a stored spare code and a freshly computed one. It classifies the pair as clean, a correctable single data-bit error (with byte offset and bit number), an error in the code itself, or uncorrectable. The parity word is ready one cycle after the last byte of a read chunk. On a write chunk it is held back by a configurable number of extra cycles.

Top module: `ecc256_engine`

## Requirements
- R1: After reset, code_valid_o and chk_done_o are low, parity_o is zero and spare_o is 24'hFFFFFF.
- R2: A byte is taken only at a rising edge where en_i and byte_valid_i are both high; any other byte has no effect on the parity or on the position within the chunk.
- R3: clear_i zeroes the accumulated parity and the chunk position; a byte presented in the same cycle as clear_i is dropped.
- R4: Over the bytes of one chunk, parity_o bit 0 is the XOR of data bits 0,2,4,6; bit 1 of bits 1,3,5,7; bit 2 of bits 0,1,4,5; bit 3 of bits 2,3,6,7; bit 4 of bits 0-3; bit 5 of bits 4-7.
- R5: For offset bit k (k = 0..7), parity_o bit 6+2k is the XOR of the byte parities of the bytes whose offset has bit k clear, and bit 7+2k is the same for bit k set. The term for k=7 with the bit set is not stored, so bits 31:21 are zero.
- R6: The 256th accepted byte ends a chunk. code_valid_o then pulses for one cycle with the new parity_o. If dir_wr_i was low with that byte, this happens at the next edge; if it was high, it happens WR_EXTRA edges later (default 2). parity_o holds between pulses.
- R7: spare_o equals the low 24 bits of the inverted parity_o shifted left by 2; spare_o[23:16] is the byte stored first, then [15:8], then [7:0].
- R8: One edge after chk_req_i is sampled high, chk_done_o is high for one cycle with chk_status_o coded 0 clean, 1 correctable, 2 code error, 3 uncorrectable; chk_done_o is low otherwise.
- R9: With d = chk_stored_i ^ chk_calc_i, and the unstored line term rebuilt from the others, the result is correctable when d bits 1:0 and 23 are zero and every even/odd line-term pair and column pair (bits 0/1, 2/3, 4/5 of the column field) differs in exactly one member. chk_byte_o bit k is the difference of the odd term for offset bit k. chk_bit_o is {column bit 5, bit 3, bit 1} of the difference.
- R10: d equal to zero gives status 0; d with exactly one bit set gives status 2; any other non-correctable d gives status 3; chk_byte_o and chk_bit_o are zero unless the status is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero parity and chunk position |
| en_i | input | 1 | Accumulation enable |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Data byte |
| dir_wr_i | input | 1 | High when the stream is a write to flash |
| code_valid_o | output | 1 | One-cycle pulse: new code published |
| parity_o | output | 32 | Raw parity word of the last chunk |
| spare_o | output | 24 | Spare-area encoding of parity_o |
| chk_req_i | input | 1 | Start a syndrome evaluation |
| chk_stored_i | input | 24 | Code read back from the spare area |
| chk_calc_i | input | 24 | Code computed over the data read |
| chk_done_o | output | 1 | Syndrome result valid |
| chk_status_o | output | 2 | Syndrome class |
| chk_byte_o | output | 8 | Offset of the failing byte |
| chk_bit_o | output | 3 | Number of the failing bit |

## Verification
The hardest case to reach is a correctable error whose byte offset needs the unstored line term. Its offset has bit 7 set, so the checker must rebuild that term from overall parity. The stimulus flips bit 7 of byte 255 and compares codes computed over the clean chunk and the corrupted one. Idle strobes (enable low, or valid low) are spread through a chunk to show that neither parity nor chunk position moves. A clear that arrives mid-chunk with a live byte must restart the count, so the next code appears exactly 256 accepted bytes later. Write chunks are checked on the exact cycle of their delayed pulse.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned COL_W       = 6;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned SPARE_W     = 24;
  localparam int unsigned SPARE_SHIFT = 2;

  typedef enum logic [1:0] {
    SYN_CLEAN    = 2'd0,
    SYN_FIXABLE  = 2'd1,
    SYN_CODE_ERR = 2'd2,
    SYN_FATAL    = 2'd3
  } syn_status_e;

  // column groups: even/odd bits, bit pairs, nibbles
  function automatic logic [COL_W-1:0] col_fold(input logic [BYTE_W-1:0] x);
    logic [COL_W-1:0] c;
    c[0] = x[0] ^ x[2] ^ x[4] ^ x[6];
    c[1] = x[1] ^ x[3] ^ x[5] ^ x[7];
    c[2] = x[0] ^ x[1] ^ x[4] ^ x[5];
    c[3] = x[2] ^ x[3] ^ x[6] ^ x[7];
    c[4] = ^x[3:0];
    c[5] = ^x[7:4];
    return c;
  endfunction

  function automatic logic [SPARE_W-1:0] spare_encode(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] s;
    s = ~(w << SPARE_SHIFT);
    return s[SPARE_W-1:0];
  endfunction
endpackage

// File: rtl/ecc256_accum.sv
module ecc256_accum
  import ecc256_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned TERMS  = 2 * AW;
  localparam int unsigned LINE_W = TERMS - 1;

  logic [AW-1:0]     cnt_q;
  logic [TERMS-1:0]  line_q, line_d;
  logic [BYTE_W-1:0] colx_q, colx_d;
  logic              take, last, bpar;

  assign take = en_i & valid_i & ~clear_i;
  assign last = &cnt_q;
  assign bpar = ^byte_i;

  // term 2k: offset bit k clear, term 2k+1: offset bit k set
  for (genvar k = 0; k < AW; k++) begin : g_line
    assign line_d[2*k]   = line_q[2*k]   ^ (bpar & ~cnt_q[k]);
    assign line_d[2*k+1] = line_q[2*k+1] ^ (bpar &  cnt_q[k]);
  end
  assign colx_d = colx_q ^ byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      line_q <= '0;
      colx_q <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      line_q <= '0;
      colx_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + AW'(1);
      if (last) begin
        line_q <= '0;
        colx_q <= '0;
      end else begin
        line_q <= line_d;
        colx_q <= colx_d;
      end
    end
  end

  assign done_o = take & last;

  always_comb begin
    word_o = '0;
    word_o[COL_W-1:0]      = col_fold(colx_d);
    word_o[COL_W +: LINE_W] = line_d[LINE_W-1:0];
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(en_i && valid_i) && !clear_i) |=> ($stable(cnt_q) && $stable(line_q) && $stable(colx_q)));

  assert_clear_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && line_q == '0 && colx_q == '0));
endmodule

// File: rtl/ecc256_publish.sv
module ecc256_publish
  import ecc256_pkg::*;
#(
  parameter int unsigned WR_EXTRA = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic               wr_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               valid_o,
  output logic [WORD_W-1:0]  word_o,
  output logic [SPARE_W-1:0] spare_o
);
  localparam int unsigned CW = $clog2(WR_EXTRA + 1);

  logic              pend_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (wr_i) begin
          pend_q <= 1'b1;
          cnt_q  <= CW'(WR_EXTRA);
          hold_q <= word_i;
        end else begin
          word_o  <= word_i;
          valid_o <= 1'b1;
        end
      end else if (pend_q) begin
        if (cnt_q == CW'(1)) begin
          pend_q  <= 1'b0;
          word_o  <= hold_q;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign spare_o = spare_encode(word_o);

  assert_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  assert_wr_late_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && wr_i) |=> !valid_o);
endmodule

// File: rtl/ecc256_syndrome.sv
module ecc256_syndrome
  import ecc256_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [SPARE_W-1:0] stored_i,
  input  logic [SPARE_W-1:0] calc_i,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic [AW-1:0]      byte_o,
  output logic [2:0]         bit_o
);
  localparam int unsigned TERMS  = 2 * AW;
  localparam int unsigned LINE_W = TERMS - 1;
  localparam int unsigned USED   = COL_W + LINE_W;
  localparam logic [SPARE_W-1:0] USED_MASK =
    ((SPARE_W'(1) << USED) - SPARE_W'(1)) << SPARE_SHIFT;

  logic [SPARE_W-1:0] diff;
  logic [COL_W-1:0]   cd;
  logic [TERMS-1:0]   ld;
  logic [AW-1:0]      pair_ok, odd_d;
  logic [2:0]         col_ok;
  logic               stray, fixable;
  syn_status_e        st;

  assign diff  = stored_i ^ calc_i;
  assign cd    = diff[SPARE_SHIFT +: COL_W];
  assign stray = |(diff & ~USED_MASK);
  assign ld[LINE_W-1:0] = diff[SPARE_SHIFT+COL_W +: LINE_W];
  // unstored term = its partner ^ overall parity (term0 ^ term1)
  assign ld[TERMS-1] = ld[TERMS-2] ^ ld[0] ^ ld[1];

  for (genvar k = 0; k < AW; k++) begin : g_pair
    assign pair_ok[k] = ld[2*k] ^ ld[2*k+1];
    assign odd_d[k]   = ld[2*k+1];
  end
  for (genvar j = 0; j < 3; j++) begin : g_col
    assign col_ok[j] = cd[2*j] ^ cd[2*j+1];
  end

  assign fixable = (&pair_ok) & (&col_ok) & ~stray;

  always_comb begin
    if (diff == '0)                 st = SYN_CLEAN;
    else if (fixable)               st = SYN_FIXABLE;
    else if ($countones(diff) == 1) st = SYN_CODE_ERR;
    else                            st = SYN_FATAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      status_o <= 2'd0;
      byte_o   <= '0;
      bit_o    <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        status_o <= st;
        byte_o   <= fixable ? odd_d : '0;
        bit_o    <= fixable ? {cd[5], cd[3], cd[1]} : 3'd0;
      end
    end
  end

  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);

  assert_fields_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o != SYN_FIXABLE) |-> (byte_o == '0 && bit_o == 3'd0));
endmodule

// File: rtl/ecc256_engine.sv
module ecc256_engine
  import ecc256_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned WR_EXTRA = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               en_i,
  input  logic               byte_valid_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               dir_wr_i,
  output logic               code_valid_o,
  output logic [WORD_W-1:0]  parity_o,
  output logic [SPARE_W-1:0] spare_o,
  input  logic               chk_req_i,
  input  logic [SPARE_W-1:0] chk_stored_i,
  input  logic [SPARE_W-1:0] chk_calc_i,
  output logic               chk_done_o,
  output logic [1:0]         chk_status_o,
  output logic [AW-1:0]      chk_byte_o,
  output logic [2:0]         chk_bit_o
);
  logic              chunk_done;
  logic [WORD_W-1:0] chunk_word;

  ecc256_accum #(.AW(AW)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .en_i    (en_i),
    .valid_i (byte_valid_i),
    .byte_i  (byte_i),
    .done_o  (chunk_done),
    .word_o  (chunk_word)
  );

  ecc256_publish #(.WR_EXTRA(WR_EXTRA)) u_publish (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (chunk_done),
    .wr_i    (dir_wr_i),
    .word_i  (chunk_word),
    .valid_o (code_valid_o),
    .word_o  (parity_o),
    .spare_o (spare_o)
  );

  ecc256_syndrome #(.AW(AW)) u_syndrome (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (chk_req_i),
    .stored_i (chk_stored_i),
    .calc_i   (chk_calc_i),
    .done_o   (chk_done_o),
    .status_o (chk_status_o),
    .byte_o   (chk_byte_o),
    .bit_o    (chk_bit_o)
  );
endmodule

// File: tb/sim_ecc256_engine.sv
`timescale 1ns/1ps
module sim_ecc256_engine;
  localparam int WR_EXTRA = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, en_i = 1'b0, byte_valid_i = 1'b0, dir_wr_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        code_valid_o;
  logic [31:0] parity_o;
  logic [23:0] spare_o;
  logic        chk_req_i = 1'b0;
  logic [23:0] chk_stored_i = '0, chk_calc_i = '0;
  logic        chk_done_o;
  logic [1:0]  chk_status_o;
  logic [7:0]  chk_byte_o;
  logic [2:0]  chk_bit_o;

  always #4 clk_i = ~clk_i;

  ecc256_engine #(.AW(8), .WR_EXTRA(WR_EXTRA)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .en_i(en_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .dir_wr_i(dir_wr_i),
    .code_valid_o(code_valid_o), .parity_o(parity_o), .spare_o(spare_o),
    .chk_req_i(chk_req_i), .chk_stored_i(chk_stored_i), .chk_calc_i(chk_calc_i),
    .chk_done_o(chk_done_o), .chk_status_o(chk_status_o),
    .chk_byte_o(chk_byte_o), .chk_bit_o(chk_bit_o)
  );

  typedef struct { logic [31:0] w; int lat; } exp_t;
  exp_t        exp_q[$];
  logic [7:0]  chunk [256];
  int          n_cmp = 0, n_bad = 0;
  int          cyc = 0, wrap_cyc = 0;
  logic [7:0]  mcnt = '0;
  int unsigned seed = 32'h1234_5678;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  // expected word from R4 and R5
  function automatic logic [31:0] ref_word();
    logic [7:0]  cx = '0;
    logic [15:0] lt = '0;
    logic [31:0] w  = '0;
    for (int i = 0; i < 256; i++) begin
      logic bp;
      cx ^= chunk[i];
      bp = ^chunk[i];
      for (int k = 0; k < 8; k++)
        if (i[k]) lt[2*k+1] ^= bp; else lt[2*k] ^= bp;
    end
    w[0] = cx[0] ^ cx[2] ^ cx[4] ^ cx[6];
    w[1] = cx[1] ^ cx[3] ^ cx[5] ^ cx[7];
    w[2] = cx[0] ^ cx[1] ^ cx[4] ^ cx[5];
    w[3] = cx[2] ^ cx[3] ^ cx[6] ^ cx[7];
    w[4] = ^cx[3:0];
    w[5] = ^cx[7:4];
    w[20:6] = lt[14:0];
    return w;
  endfunction

  function automatic logic [23:0] ref_spare(input logic [31:0] w);
    logic [31:0] s;
    s = ~(w << 2);
    return s[23:0];
  endfunction

  // bench view of accepted bytes (R2, R3, R6)
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (!rst_ni) mcnt <= '0;
    else if (clear_i) mcnt <= '0;
    else if (en_i && byte_valid_i) begin
      mcnt <= mcnt + 8'd1;
      if (mcnt == 8'hFF) wrap_cyc <= cyc;
    end
  end

  // monitor: pop and compare each published code
  always @(negedge clk_i) begin
    if (rst_ni && code_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected code pulse", parity_o, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(parity_o[5:0] == e.w[5:0], "R4 column parity", parity_o, e.w);
        check(parity_o[31:6] == e.w[31:6], "R5 line parity", parity_o, e.w);
        check(spare_o == ref_spare(e.w), "R7 spare code", {8'h0, spare_o}, {8'h0, ref_spare(e.w)});
        check(cyc - wrap_cyc == e.lat, "R6 code latency", cyc - wrap_cyc, e.lat);
      end
    end
  end

  task automatic fill_rand();
    for (int i = 0; i < 256; i++) chunk[i] = rnd();
  endtask

  task automatic feed(input bit wr, input bit gaps);
    exp_t e;
    e.w = ref_word();
    e.lat = wr ? WR_EXTRA + 1 : 1;
    exp_q.push_back(e);
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 37) == 5) begin
        @(negedge clk_i); en_i = 1'b0; byte_valid_i = 1'b1; byte_i = ~chunk[i]; dir_wr_i = wr;
        @(negedge clk_i); en_i = 1'b1; byte_valid_i = 1'b0; byte_i = 8'h5C;
      end
      @(negedge clk_i);
      en_i = 1'b1; byte_valid_i = 1'b1; byte_i = chunk[i]; dir_wr_i = wr;
    end
    @(negedge clk_i);
    en_i = 1'b0; byte_valid_i = 1'b0;
  endtask

  task automatic settle();
    repeat (WR_EXTRA + 4) @(negedge clk_i);
  endtask

  task automatic syn(input logic [23:0] st, input logic [23:0] ca, input logic [1:0] es,
                     input logic [7:0] eb, input logic [2:0] ebit, input string req);
    @(negedge clk_i);
    chk_stored_i = st; chk_calc_i = ca; chk_req_i = 1'b1;
    @(negedge clk_i);
    chk_req_i = 1'b0;
    check(chk_done_o == 1'b1, "R8 done after request", chk_done_o, 1);
    check(chk_status_o == es, {req, " status"}, chk_status_o, es);
    check(chk_byte_o == eb, {req, " byte offset"}, chk_byte_o, eb);
    check(chk_bit_o == ebit, {req, " bit number"}, chk_bit_o, ebit);
    @(negedge clk_i);
    check(chk_done_o == 1'b0, "R8 done is a single cycle", chk_done_o, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [23:0] s0, s1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(code_valid_o == 1'b0, "R1 code_valid after reset", code_valid_o, 0);
    check(parity_o == 32'h0, "R1 parity after reset", parity_o, 0);
    check(spare_o == 24'hFFFFFF, "R1 spare after reset", spare_o, 32'hFFFFFF);
    check(chk_done_o == 1'b0, "R1 chk_done after reset", chk_done_o, 0);

    // R4 R5 R6: zeros, ones, ramp on the read path
    for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
    feed(1'b0, 1'b0); settle();
    for (int i = 0; i < 256; i++) chunk[i] = 8'hFF;
    feed(1'b0, 1'b0); settle();
    for (int i = 0; i < 256; i++) chunk[i] = 8'(i);
    feed(1'b0, 1'b0); settle();

    // R6 write path latency
    fill_rand();
    feed(1'b1, 1'b0); settle();

    // R2 idle strobes inside a chunk with one lone set bit
    for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
    chunk[8'hA5] = 8'h08;
    feed(1'b0, 1'b1); settle();

    // R3 clear mid-chunk, live byte dropped
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i); en_i = 1'b1; byte_valid_i = 1'b1; byte_i = rnd(); dir_wr_i = 1'b0;
    end
    @(negedge clk_i); clear_i = 1'b1; byte_i = 8'h77;
    @(negedge clk_i); clear_i = 1'b0; en_i = 1'b0; byte_valid_i = 1'b0;
    fill_rand();
    feed(1'b0, 1'b0); settle();

    // back-to-back chunks, write then read
    fill_rand();
    feed(1'b1, 1'b0);
    fill_rand();
    feed(1'b0, 1'b0); settle();
    check(exp_q.size() == 0, "R6 every chunk produced a code", exp_q.size(), 0);

    // syndrome cases R9 R10
    fill_rand();
    s0 = ref_spare(ref_word());
    syn(s0, s0, 2'd0, 8'h00, 3'd0, "R10 clean");
    chunk[8'h5A] ^= 8'h08;
    s1 = ref_spare(ref_word());
    syn(s0, s1, 2'd1, 8'h5A, 3'd3, "R9 single flip 0x5A.3");
    chunk[8'h5A] ^= 8'h08;
    chunk[8'hFF] ^= 8'h80;
    s1 = ref_spare(ref_word());
    syn(s0, s1, 2'd1, 8'hFF, 3'd7, "R9 rebuilt term 0xFF.7");
    chunk[8'hFF] ^= 8'h80;
    chunk[0] ^= 8'h01;
    s1 = ref_spare(ref_word());
    syn(s1, s0, 2'd1, 8'h00, 3'd0, "R9 single flip 0x00.0");
    chunk[0] ^= 8'h01;
    syn(s0, s0 ^ 24'h000400, 2'd2, 8'h00, 3'd0, "R10 code bit error");
    syn(s0, s0 ^ 24'h000001, 2'd2, 8'h00, 3'd0, "R10 pad bit error");
    chunk[8'h33] ^= 8'h03;
    s1 = ref_spare(ref_word());
    syn(s0, s1, 2'd3, 8'h00, 3'd0, "R10 double flip");

    finish_run();
  end
endmodule